// File: doc/BRIEF.md
# I2C Master-Receive Byte Queue with Transfer Counter

This block manages the flow of received data on the controller side of an I2C master read. The bit-level engine hands it one byte at a time through a strobe. The byte goes into a small first-in, first-out queue, and software drains the queue through a register port. Before a read starts, software loads a down-counter with the number of bytes it wants. The counter drops by one for every byte that comes off the bus. The block uses it to tell the bit engine whether the next byte gets an acknowledge or the final not-acknowledge.

A hold bit in the control word changes what happens when the queue is full. With the hold bit set, the block asks the bit engine to stretch the clock instead of losing data. Without it, a byte that arrives while the queue is full is dropped and reported. Single-cycle event pulses mark four conditions: the fill level reaching the threshold, the last counted byte, an overflow, and an underflow. A control bit flushes the queue.

Register map (byte-wide data, 6-bit offset): control at 0x00, status at 0x04, receive data at 0x0C, transfer count at 0x14.

Top module: `i2c_rx_flow`

## Requirements
- R1: Bytes read from offset 0x0C come out in the order they were strobed in, and the queue holds up to DEPTH (default 16) bytes.
- R2: Status bit 5 (offset 0x04) reads 1 exactly when the queue holds at least one byte.
- R3: A byte strobed while the queue is full is discarded, and `evt_ovf` pulses one cycle after the strobe. The queue contents are unchanged.
- R4: A read of offset 0x0C while the queue is empty returns 0 and pulses `evt_unf` for one cycle.
- R5: `evt_thresh` pulses one cycle after the strobe that brings the fill level to DEPTH-2 (14 by default), and at no other strobe.
- R6: A write to offset 0x14 loads the count from data bits 7:0. Each byte strobe lowers the count by one, and the count stays at 0 once it gets there. A read of 0x14 returns the live count.
- R7: `ack_next` is 1 while the count is 2 or more and 0 while it is 1 or 0. The byte that takes the count to zero is therefore not acknowledged.
- R8: `evt_done` pulses one cycle after the strobe that takes the count from 1 to 0, and at no other time.
- R9: `stall` is 1 exactly while control bit 4 (hold) is set and the queue is full. The hold bit never forces `ack_next` high.
- R10: Writing control with bit 6 set empties the queue. Bit 6 reads back as 0, and bit 4 reads back as written.
- R11: After reset the queue is empty, the count and the hold bit are 0, and `ack_next`, `stall` and all events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a byte was received from the bus |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| ack_next | output | 1 | 1: acknowledge the next byte; 0: not-acknowledge it |
| stall | output | 1 | Request to stretch the bus clock |
| evt_thresh | output | 1 | Fill level reached DEPTH-2 |
| evt_done | output | 1 | Last counted byte received |
| evt_ovf | output | 1 | Byte lost to a full queue |
| evt_unf | output | 1 | Data read from an empty queue |

## Verification
Every event pulse and every read result is registered. Each one is due in the cycle right after the clock edge that samples its strobe. `ack_next` and `stall` are decoded from registered state, so they take their new value right after that same edge. The bench drives each strobe on a falling edge and samples all outputs on the next falling edge, one full edge after the cause. It reads `ack_next` just before the strobe that the value applies to. A near-exhaustive sweep loads counts from 0 to 8 and checks the acknowledge and completion result byte by byte against a remaining-count model kept in the bench.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

    localparam int REG_AW = 6;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_STAT  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_DATA  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_COUNT = 6'h14;

    localparam int BIT_HOLD  = 4;
    localparam int BIT_AVAIL = 5;
    localparam int BIT_FLUSH = 6;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_STAT,
        RS_DATA,
        RS_COUNT
    } reg_sel_e;

    typedef struct packed {
        logic thresh;
        logic done;
        logic ovf;
        logic unf;
    } rx_evt_t;

    function automatic reg_sel_e decode_sel(input logic [REG_AW-1:0] a);
        case (a)
            OFS_CTRL:  return RS_CTRL;
            OFS_STAT:  return RS_STAT;
            OFS_DATA:  return RS_DATA;
            OFS_COUNT: return RS_COUNT;
            default:   return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] lvl;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (lvl == '0);
    assign full    = (lvl == LW'(DEPTH));
    assign level   = lvl;
    assign dout    = mem[rp];
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            lvl <= lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && count != '0)
            count <= count - W'(1);
    end

    assign last = (count == W'(1));
endmodule

// File: rtl/i2c_rx_flow.sv
module i2c_rx_flow
    import i2crx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int THR  = DEPTH - 2,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              ack_next,
    output logic              stall,
    output logic              evt_thresh,
    output logic              evt_done,
    output logic              evt_ovf,
    output logic              evt_unf
);
    reg_sel_e          sel;
    logic              wr_ctrl, wr_cnt, rd_fifo, flush;
    logic              hold_q;
    logic [7:0]        q_dout;
    logic              q_empty, q_full;
    logic [LW-1:0]     q_level;
    logic [REG_DW-1:0] cnt_q;
    logic              cnt_last;
    rx_evt_t           evt_d, evt_q;

    assign sel     = decode_sel(reg_addr);
    assign wr_ctrl = reg_wr && (sel == RS_CTRL);
    assign wr_cnt  = reg_wr && (sel == RS_COUNT);
    assign rd_fifo = reg_rd && (sel == RS_DATA);
    assign flush   = wr_ctrl && reg_wdata[BIT_FLUSH];

    rxq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .clr(flush),
        .push(rx_valid), .pop(rd_fifo), .din(rx_byte),
        .dout(q_dout), .empty(q_empty), .full(q_full), .level(q_level)
    );

    xfer_counter #(.W(REG_DW)) u_cnt (
        .clk(clk), .rst(rst), .load(wr_cnt), .load_val(reg_wdata),
        .tick(rx_valid), .count(cnt_q), .last(cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= 1'b0;
        else if (wr_ctrl) hold_q <= reg_wdata[BIT_HOLD];
    end

    assign ack_next = (cnt_q > REG_DW'(1));
    assign stall    = hold_q && q_full;

    always_comb begin
        evt_d.thresh = rx_valid && !q_full && !flush
                       && !(rd_fifo && !q_empty)
                       && (q_level == LW'(THR - 1));
        evt_d.done   = rx_valid && !wr_cnt && cnt_last;
        evt_d.ovf    = rx_valid && q_full && !flush;
        evt_d.unf    = rd_fifo && q_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_d;
    end

    assign evt_thresh = evt_q.thresh;
    assign evt_done   = evt_q.done;
    assign evt_ovf    = evt_q.ovf;
    assign evt_unf    = evt_q.unf;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            case (sel)
                RS_CTRL:  reg_rdata[BIT_HOLD]  <= hold_q;
                RS_STAT:  reg_rdata[BIT_AVAIL] <= !q_empty;
                RS_DATA:  reg_rdata <= q_empty ? '0 : q_dout;
                RS_COUNT: reg_rdata <= cnt_q;
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_rx_flow_chk.sv
module i2c_rx_flow_chk
    import i2crx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              ack_next,
    input logic              stall,
    input logic              evt_thresh,
    input logic              evt_done,
    input logic              evt_ovf,
    input logic              evt_unf
);
    p_done_after_nack_r8: assert property (@(posedge clk) disable iff (rst)
        evt_done |-> $past(rx_valid && !ack_next));

    p_zero_load_nacks_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_COUNT && reg_wdata == '0 && !rx_valid) |=> !ack_next);

    p_ovf_from_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        evt_ovf |-> $past(rx_valid));

    p_unf_from_read_r4: assert property (@(posedge clk) disable iff (rst)
        evt_unf |-> ($past(reg_rd && reg_addr == OFS_DATA) && reg_rdata == '0));

    p_thresh_from_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        evt_thresh |-> $past(rx_valid));

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (stall && !reg_wr && !reg_rd) |=> stall);

    p_thresh_not_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_thresh, evt_ovf}));
endmodule

bind i2c_rx_flow i2c_rx_flow_chk u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_next(ack_next), .stall(stall), .evt_thresh(evt_thresh),
    .evt_done(evt_done), .evt_ovf(evt_ovf), .evt_unf(evt_unf)
);

// File: tb/i2c_rx_flow_tb.sv
module i2c_rx_flow_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_next, stall, evt_thresh, evt_done, evt_ovf, evt_unf;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_DATA = 6'h0C, A_CNT = 6'h14;

    i2c_rx_flow u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_next(ack_next), .stall(stall),
        .evt_thresh(evt_thresh), .evt_done(evt_done), .evt_ovf(evt_ovf), .evt_unf(evt_unf)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] b, output bit th, output bit dn, output bit ov);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        th = evt_thresh; dn = evt_done; ov = evt_ovf;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d, output bit u);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata; u = evt_unf;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        wrap_up();
    end

    initial begin
        logic [7:0] d;
        bit th, dn, ov, u;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk(ack_next == 1'b0, "R11 ack", ack_next, 0);
        chk(stall == 1'b0, "R11 stall", stall, 0);
        chk({evt_thresh, evt_done, evt_ovf, evt_unf} == 4'b0, "R11 events", 0, 0);
        rd(A_STAT, d, u);
        chk(d[5] == 1'b0, "R11 status empty", d[5], 0);
        rd(A_CNT, d, u);
        chk(d == 8'd0, "R11 count", d, 0);

        // Fill past capacity, hold clear: R1 R3 R5 R7
        wr(A_CNT, 8'd20);
        cnt = 20;
        for (int i = 0; i < 18; i++) begin
            chk(ack_next == (cnt > 1), "R7 ack while counting", ack_next, cnt > 1);
            push(8'hA0 + 8'(i), th, dn, ov);
            cnt--;
            chk(th == (i == 13), "R5 threshold pulse", th, i == 13);
            chk(ov == (i >= 16), "R3 overflow pulse", ov, i >= 16);
            chk(dn == 1'b0, "R8 no early done", dn, 0);
        end
        chk(stall == 1'b0, "R9 no stall without hold", stall, 0);
        rd(A_CNT, d, u);
        chk(d == 8'd2, "R6 live count", d, 2);
        rd(A_STAT, d, u);
        chk(d[5] == 1'b1, "R2 status avail", d[5], 1);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, d, u);
            chk(d == 8'hA0 + 8'(i), "R1 order", d, 8'hA0 + i);
            chk(u == 1'b0, "R4 no underflow", u, 0);
        end
        rd(A_DATA, d, u);
        chk(d == 8'd0, "R4 empty read value", d, 0);
        chk(u == 1'b1, "R4 underflow pulse", u, 1);
        rd(A_STAT, d, u);
        chk(d[5] == 1'b0, "R2 status empty", d[5], 0);

        // Count end: R7 R8 R6
        chk(ack_next == 1'b1, "R7 ack at 2", ack_next, 1);
        push(8'h11, th, dn, ov);
        chk(dn == 1'b0, "R8 no done at 2->1", dn, 0);
        chk(ack_next == 1'b0, "R7 nack at 1", ack_next, 0);
        push(8'h12, th, dn, ov);
        chk(dn == 1'b1, "R8 done at 1->0", dn, 1);
        push(8'h13, th, dn, ov);
        chk(dn == 1'b0, "R8 no done at 0", dn, 0);
        rd(A_CNT, d, u);
        chk(d == 8'd0, "R6 saturate at zero", d, 0);
        for (int i = 0; i < 3; i++) begin
            rd(A_DATA, d, u);
            chk(d == 8'h11 + 8'(i), "R1 order after count end", d, 8'h11 + i);
        end

        // Hold: R9 R10
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, d, u);
        chk(d == 8'h10, "R10 hold readback", d, 8'h10);
        wr(A_CNT, 8'd5);
        for (int i = 0; i < 16; i++) begin
            chk(stall == 1'b0, "R9 no stall before full", stall, 0);
            push(8'(i), th, dn, ov);
        end
        chk(stall == 1'b1, "R9 stall when full with hold", stall, 1);
        chk(ack_next == 1'b0, "R9 hold does not force ack", ack_next, 0);
        rd(A_DATA, d, u);
        chk(d == 8'd0, "R1 head under hold", d, 0);
        chk(stall == 1'b0, "R9 stall released by read", stall, 0);
        push(8'h55, th, dn, ov);
        chk(stall == 1'b1, "R9 stall again", stall, 1);

        // Flush: R10
        wr(A_CTRL, 8'h50);
        chk(stall == 1'b0, "R10 flush empties", stall, 0);
        rd(A_CTRL, d, u);
        chk(d == 8'h10, "R10 flush bit reads 0", d, 8'h10);
        rd(A_STAT, d, u);
        chk(d[5] == 1'b0, "R10 status after flush", d[5], 0);
        rd(A_DATA, d, u);
        chk(u == 1'b1, "R10 R4 empty after flush", u, 1);
        wr(A_CTRL, 8'h00);

        // Sweep of small counts: R6 R7 R8
        for (int l = 0; l <= 8; l++) begin
            wr(A_CNT, 8'(l));
            for (int k = 0; k <= l; k++) begin
                int r;
                r = (l - k > 0) ? l - k : 0;
                chk(ack_next == (r > 1), "R7 sweep ack", ack_next, r > 1);
                push(8'(16 * l + k), th, dn, ov);
                chk(dn == (r == 1), "R8 sweep done", dn, r == 1);
                rd(A_DATA, d, u);
                chk(d == 8'(16 * l + k), "R1 sweep data", d, 16 * l + k);
            end
            rd(A_CNT, d, u);
            chk(d == 8'd0, "R6 sweep final count", d, 0);
        end

        wrap_up();
    end
endmodule